// File: doc/BRIEF.md
# Flash Autoselect Command Decoder

This block watches the write and read bus cycles of a dual-bank NOR-style memory and recognises the command sequence that puts one bank into identification mode. The sequence has two unlock writes and then a command write carrying 90h. The top address bit of that third write chooses the bank. While the mode is active, reads to the chosen bank return a manufacturer code, a device code or the write-protect status of the addressed block. The result depends on address bits A6, A1 and A0. Reads to the other bank still return array data. A write of F0h leaves the mode.

The array itself lives outside the block. Its read data comes in on `array_data`, and the block passes it through whenever the identification path does not apply. The per-block protect bits sit in a register loaded through a plain load strobe.

Top module: `flash_idmode_decoder`

## Requirements
- R1: After reset `id_active` is 0, `id_bank` is 0, `rd_data` is 0 and every protect bit is 0.
- R2: Three writes enter identification mode: data AAh at low address 555h, then 55h at 2AAh, then 90h. Only `wr_addr[10:0]` is compared. From the cycle after the third write, `id_active` is 1 and `id_bank` equals bit 15 of that third write's address.
- R3: A write that does not match the expected unlock step sends the sequencer back to idle, so a following 90h write does not enter the mode.
- R4: In the mode, a read in the selected bank with (A6,A1,A0)=(0,0,0) returns the manufacturer code 0037h.
- R5: In the mode, a read in the selected bank with (A6,A1,A0)=(0,0,1) returns the device code 22B4h.
- R6: In the mode, a read in the selected bank with (A6,A1,A0)=(0,1,0) returns on bit 0 the protect bit of the block selected by `rd_addr[15:12]`, with bits 15..1 at 0.
- R7: In the mode, reads whose address bit 15 differs from `id_bank` return `array_data`.
- R8: A write of F0h at any address ends the mode, and later reads return `array_data`.
- R9: Outside the mode, every read returns `array_data`.
- R10: `rd_data` takes its new value in the cycle after `rd_en` and holds it while `rd_en` is low.
- R11: In the mode, writes other than F0h have no effect: `id_active` and `id_bank` stay unchanged.
- R12: In the mode, reads in the selected bank with any other (A6,A1,A0) pattern return 0.
- R13: `prot_load` high copies `prot_value` into the protect register at the clock edge. Bit n guards block n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write command byte |
| rd_en | input | 1 | Read cycle strobe |
| rd_addr | input | 16 | Read address |
| array_data | input | 16 | Array data for the current read |
| prot_load | input | 1 | Load strobe for the protect register |
| prot_value | input | 16 | New protect bits, one per block |
| rd_data | output | 16 | Registered read result |
| id_active | output | 1 | Identification mode active |
| id_bank | output | 1 | Bank selected for identification |

## Verification
The hardest situation to reach is a broken unlock sequence that is still followed by a valid-looking 90h write. The block must ignore that 90h write, and only the data on a later read shows the difference. The stimulus breaks the sequence at the first step with a wrong address and at the second step with a wrong data byte. Each broken sequence ends with a 90h write and a read that must still return array data. A further case sets high address bits on the unlock writes, which must not spoil entry. Entry into the upper bank is checked with protect reads in both banks.

// File: rtl/fid_pkg.sv
// Package: shared types for the identification-mode command decoder.
// Assumes nothing beyond the command sequencer being its only user.
package fid_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STEP1 = 2'd1,
        SEQ_STEP2 = 2'd2,
        SEQ_ID    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fid_cmd_seq.sv
// Command sequencer: tracks unlock writes and enters/leaves identification mode.
// Assumes one write per strobe cycle; only the low CMP_W address bits matter for unlock.
module fid_cmd_seq
    import fid_pkg::*;
#(
    parameter int          CMP_W     = 11,
    parameter logic [10:0] UNL_ADDR1 = 11'h555,
    parameter logic [10:0] UNL_ADDR2 = 11'h2AA,
    parameter logic [7:0]  UNL_DATA1 = 8'hAA,
    parameter logic [7:0]  UNL_DATA2 = 8'h55,
    parameter logic [7:0]  CMD_ID    = 8'h90,
    parameter logic [7:0]  CMD_EXIT  = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_addr_lo,
    input  logic             wr_bank,
    input  logic [7:0]       wr_data,
    output logic             id_active,
    output logic             id_bank
);
    seq_state_t state, state_nxt;
    logic       step1_hit, step2_hit;

    assign step1_hit = (wr_addr_lo == UNL_ADDR1[CMP_W-1:0]) && (wr_data == UNL_DATA1);
    assign step2_hit = (wr_addr_lo == UNL_ADDR2[CMP_W-1:0]) && (wr_data == UNL_DATA2);

    // Next-state decode for each write strobe.
    always_comb begin
        state_nxt = state;
        if (wr_en) begin
            unique case (state)
                SEQ_IDLE:  state_nxt = step1_hit ? SEQ_STEP1 : SEQ_IDLE;
                SEQ_STEP1: state_nxt = step2_hit ? SEQ_STEP2 : SEQ_IDLE;
                SEQ_STEP2: state_nxt = (wr_data == CMD_ID) ? SEQ_ID : SEQ_IDLE;
                SEQ_ID:    state_nxt = (wr_data == CMD_EXIT) ? SEQ_IDLE : SEQ_ID;
                default:   state_nxt = SEQ_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    // Bank capture on the command write that enters the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_bank <= 1'b0;
        else if (wr_en && state == SEQ_STEP2 && wr_data == CMD_ID)
            id_bank <= wr_bank;
    end

    assign id_active = (state == SEQ_ID);

    a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == SEQ_STEP2 && wr_data == CMD_ID) |=> (id_active && id_bank == $past(wr_bank)));
    a_r3_bad_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == SEQ_STEP1 && !step2_hit) |=> (state == SEQ_IDLE));
    a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (id_active && wr_en && wr_data == CMD_EXIT) |=> !id_active);
    a_r11_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (id_active && !(wr_en && wr_data == CMD_EXIT)) |=> (id_active && $stable(id_bank)));
endmodule

// File: rtl/fid_prot_reg.sv
// Protect register: one write-protect bit per block, loaded in one go.
// Assumes the loader presents all bits together with the load strobe.
module fid_prot_reg #(
    parameter int NBLK = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NBLK-1:0] value,
    output logic [NBLK-1:0] bits
);
    // Clear on reset, copy on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    bits <= '0;
        else if (load) bits <= value;
    end

    a_r13_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bits == $past(value)));
endmodule

// File: rtl/fid_read_mux.sv
// Read path: picks identification codes, protect status or array data, registered.
// Assumes bank is the top address bit and blocks are indexed from BLK_LSB upward.
module fid_read_mux #(
    parameter int            ADDR_W  = 16,
    parameter int            DATA_W  = 16,
    parameter int            BLK_LSB = 12,
    parameter logic [15:0]   MFR_ID  = 16'h0037,
    parameter logic [15:0]   DEV_ID  = 16'h22B4,
    localparam int           NBLK    = 1 << (ADDR_W - BLK_LSB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic              id_active,
    input  logic              id_bank,
    input  logic [NBLK-1:0]   prot_bits,
    output logic [DATA_W-1:0] rd_data
);
    logic [2:0]              sel;
    logic                    id_hit;
    logic [ADDR_W-BLK_LSB-1:0] blk_idx;
    logic [DATA_W-1:0]       rd_nxt;

    assign sel     = {rd_addr[6], rd_addr[1], rd_addr[0]};
    assign id_hit  = id_active && (rd_addr[ADDR_W-1] == id_bank);
    assign blk_idx = rd_addr[ADDR_W-1:BLK_LSB];

    // Source selection for the read result.
    always_comb begin
        rd_nxt = array_data;
        if (id_hit) begin
            unique case (sel)
                3'b000:  rd_nxt = MFR_ID[DATA_W-1:0];
                3'b001:  rd_nxt = DEV_ID[DATA_W-1:0];
                3'b010:  rd_nxt = {{(DATA_W-1){1'b0}}, prot_bits[blk_idx]};
                default: rd_nxt = '0;
            endcase
        end
    end

    // Output register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_nxt;
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_hit && sel == 3'b010) |=> (rd_data[DATA_W-1:1] == '0));
    a_r7_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !id_hit) |=> (rd_data == $past(array_data)));
endmodule

// File: rtl/flash_idmode_decoder.sv
// Top: identification-mode command decoder for a two-bank NOR-style memory.
// Assumes word addressing, bank on the top address bit, blocks from bit BLK_LSB up.
module flash_idmode_decoder #(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 16,
    parameter int          BLK_LSB = 12,
    parameter int          CMP_W   = 11,
    parameter logic [15:0] MFR_ID  = 16'h0037,
    parameter logic [15:0] DEV_ID  = 16'h22B4,
    localparam int         NBLK    = 1 << (ADDR_W - BLK_LSB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    input  logic              prot_load,
    input  logic [NBLK-1:0]   prot_value,
    output logic [DATA_W-1:0] rd_data,
    output logic              id_active,
    output logic              id_bank
);
    logic [NBLK-1:0] prot_bits;

    fid_cmd_seq #(.CMP_W(CMP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr_lo (wr_addr[CMP_W-1:0]),
        .wr_bank    (wr_addr[ADDR_W-1]),
        .wr_data    (wr_data),
        .id_active  (id_active),
        .id_bank    (id_bank)
    );

    fid_prot_reg #(.NBLK(NBLK)) u_prot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (prot_load),
        .value (prot_value),
        .bits  (prot_bits)
    );

    fid_read_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BLK_LSB(BLK_LSB),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .id_active  (id_active),
        .id_bank    (id_bank),
        .prot_bits  (prot_bits),
        .rd_data    (rd_data)
    );

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (!id_active && !id_bank && rd_data == '0));
endmodule

// File: tb/flash_idmode_decoder_tb.sv
module flash_idmode_decoder_tb;
    localparam logic [15:0] MFR = 16'h0037;
    localparam logic [15:0] DEV = 16'h22B4;
    localparam int NV = 37;

    // {is_read, addr, data (write byte or array data), expected read}
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 16'h0000, 16'h1111, 16'h1111},  // R9 normal read
        {1'b0, 16'h0555, 16'h00AA, 16'h0000},
        {1'b0, 16'h02AA, 16'h0055, 16'h0000},
        {1'b0, 16'h0555, 16'h0090, 16'h0000},  // R2 enter bank 0
        {1'b1, 16'h0000, 16'h9999, MFR},       // R4
        {1'b1, 16'h0001, 16'h9999, DEV},       // R5
        {1'b1, 16'h5002, 16'h9999, 16'h0001},  // R6 block 5 protected
        {1'b1, 16'h4002, 16'hFFFF, 16'h0000},  // R6 block 4 open
        {1'b1, 16'h0003, 16'h9999, 16'h0000},  // R12
        {1'b1, 16'h0040, 16'h9999, 16'h0000},  // R12 A6 set
        {1'b1, 16'h8000, 16'h7777, 16'h7777},  // R7 other bank
        {1'b0, 16'h0555, 16'h00AA, 16'h0000},  // R11 ignored
        {1'b1, 16'h0001, 16'h9999, DEV},       // R11 still in mode
        {1'b0, 16'h0000, 16'h00F0, 16'h0000},  // R8 exit
        {1'b1, 16'h0000, 16'h4242, 16'h4242},  // R8
        {1'b0, 16'h0555, 16'h00AA, 16'h0000},
        {1'b0, 16'h02AA, 16'h0055, 16'h0000},
        {1'b0, 16'h8555, 16'h0090, 16'h0000},  // R2 enter bank 1
        {1'b1, 16'hF002, 16'h0000, 16'h0001},  // R6 block 15
        {1'b1, 16'hA002, 16'h0000, 16'h0001},  // R6 block 10
        {1'b1, 16'h9002, 16'hFFFF, 16'h0000},  // R6 block 9
        {1'b1, 16'h8001, 16'h0000, DEV},       // R5 bank 1
        {1'b1, 16'h5002, 16'h3333, 16'h3333},  // R7 bank 0 now array
        {1'b0, 16'h8000, 16'h00F0, 16'h0000},  // R8 exit
        {1'b0, 16'h0555, 16'h00AA, 16'h0000},
        {1'b0, 16'h02AA, 16'h0054, 16'h0000},  // R3 bad data step 2
        {1'b0, 16'h0555, 16'h0090, 16'h0000},
        {1'b1, 16'h0000, 16'h5A5A, 16'h5A5A},  // R3 not entered
        {1'b0, 16'h0556, 16'h00AA, 16'h0000},  // R3 bad addr step 1
        {1'b0, 16'h02AA, 16'h0055, 16'h0000},
        {1'b0, 16'h0555, 16'h0090, 16'h0000},
        {1'b1, 16'h0001, 16'hA5A5, 16'hA5A5},  // R3 not entered
        {1'b0, 16'h7555, 16'h00AA, 16'h0000},  // R2 high bits ignored
        {1'b0, 16'h12AA, 16'h0055, 16'h0000},
        {1'b0, 16'h0555, 16'h0090, 16'h0000},
        {1'b1, 16'h0000, 16'h0000, MFR},       // R2
        {1'b0, 16'h0123, 16'h00F0, 16'h0000}   // R8 exit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, prot_load = 1'b0;
    logic [15:0] wr_addr = '0, rd_addr = '0, array_data = '0, prot_value = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_data;
    logic        id_active, id_bank;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    flash_idmode_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .array_data(array_data),
        .prot_load(prot_load), .prot_value(prot_value),
        .rd_data(rd_data), .id_active(id_active), .id_bank(id_bank)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, input logic [15:0] arr);
        @(negedge clk); rd_en = 1'b1; rd_addr = a; array_data = arr;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 id_active", {15'd0, id_active}, 16'h0000);
        chk("R1 id_bank", {15'd0, id_bank}, 16'h0000);
        chk("R1 rd_data", rd_data, 16'h0000);

        // R13: load protect bits for blocks 0, 5, 10, 15
        @(negedge clk); prot_load = 1'b1; prot_value = 16'h8421;
        @(negedge clk); prot_load = 1'b0; prot_value = 16'h0000;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][48]) begin
                do_rd(VEC[i][47:32], VEC[i][31:16]);
                chk($sformatf("vector %0d", i), rd_data, VEC[i][15:0]);
            end else begin
                do_wr(VEC[i][47:32], VEC[i][23:16]);
            end
            if (i == 3)  chk("R2 active bank0", {14'd0, id_active, id_bank}, 16'h0002);
            if (i == 17) chk("R2 active bank1", {14'd0, id_active, id_bank}, 16'h0003);
            if (i == 11) chk("R11 mode kept", {14'd0, id_active, id_bank}, 16'h0002);
            if (i == 26) chk("R3 no entry", {15'd0, id_active}, 16'h0000);
            if (i == 36) chk("R8 left mode", {15'd0, id_active}, 16'h0000);
        end

        // R10: no read strobe, output holds despite new address and array data
        do_rd(16'h0000, 16'hBEEF);
        @(negedge clk); rd_addr = 16'h0001; array_data = 16'hCAFE;
        repeat (2) @(negedge clk);
        chk("R10 hold", rd_data, 16'hBEEF);

        // R1: reset leaves mode and clears protect bits
        do_wr(16'h0555, 8'hAA); do_wr(16'h02AA, 8'h55); do_wr(16'h0555, 8'h90);
        do_reset();
        chk("R1 mode cleared", {14'd0, id_active, id_bank}, 16'h0000);
        chk("R1 rd_data cleared", rd_data, 16'h0000);
        do_wr(16'h0555, 8'hAA); do_wr(16'h02AA, 8'h55); do_wr(16'h0555, 8'h90);
        do_rd(16'h0002, 16'h1234);
        chk("R1 protect cleared", rd_data, 16'h0000);

        // R13: reload, block 0 now protected
        @(negedge clk); prot_load = 1'b1; prot_value = 16'h0001;
        @(negedge clk); prot_load = 1'b0;
        do_rd(16'h0002, 16'h1234);
        chk("R13 reload", rd_data, 16'h0001);
        do_wr(16'h0000, 8'hF0);
        do_rd(16'h0002, 16'h1234);
        chk("R9 after exit", rd_data, 16'h1234);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule